// File: doc/BRIEF.md
# ISA-Style Bus Cycle Timer

This block runs one 8/16-bit ISA-style bus cycle at a time from a clock whose period is the timing unit, normally a 10 ns tick from a 100 MHz clock. A requester presents an address, write data, a read/write flag and a memory/I-O flag with a one-cycle `reqValid`. The block then drives the address (and, for writes, the data) through a setup phase. It asserts the one strobe that matches the access kind, IOR#, IOW#, MEMR# or MEMW#, and keeps the bus valid through a short hold phase. At the end it returns the sampled read data and a one-cycle completion pulse.

The phase lengths come from a small control register. The setup and strobe lengths are each a fixed two-tick minimum plus a programmable extension. The hold is a fixed two ticks. When the early-end enable is set, an active-low zero-wait-state input cuts the remaining strobe time short. Decoding of addresses and selection of the bus oscillator belong to the surrounding logic.

Top module: `isa_cycle_timer`

## Requirements
- R1: After reset the block is idle: `busy` and `done` are low, all four strobes are high, `busDataOe` is low, and `ctrlQ` reads 0x3A8 (strobe extension 40, setup extension 14, early-end off).
- R2: A request is accepted only on a clock edge where the block is idle; `reqValid` while busy has no effect on the running cycle's address, data, kind or length.
- R3: The setup phase lasts 2 + `ctrlQ[9:6]` clock cycles, starting the cycle after acceptance, with the address on `busAddr` and no strobe active.
- R4: During the strobe phase exactly one strobe is low, chosen by {mem, write}: {0,0} `iorN`, {0,1} `iowN`, {1,0} `memrN`, {1,1} `memwN`; outside it all four are high.
- R5: Without early end, the strobe phase lasts 2 + `ctrlQ[5:0]` clock cycles.
- R6: The hold phase lasts 2 cycles after the strobe; address and `busy` stay valid and no strobe is active.
- R7: `busy` is high from the cycle after acceptance through the last hold cycle; in the following cycle `busy` is low and `done` is high for exactly one cycle.
- R8: `rdData` takes the value of `busDataIn` at the clock edge that ends the strobe and holds it until the next such edge.
- R9: With `ctrlQ[10]` set, `endxN` low at a strobe-phase edge ends the strobe at that edge and the hold follows; with `ctrlQ[10]` clear, `endxN` is ignored.
- R10: A write through `ctrlWe` replaces all 11 control bits. The register values present at the accepting edge govern the whole cycle, and a write during a cycle does not change it.
- R11: `busDataOe` is high on every busy cycle of a write and low otherwise, and `busDataOut` then carries the request's write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one tick per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMem | input | 1 | 1 = memory space, 0 = I/O space |
| reqAddr | input | 24 | Request address |
| reqWdata | input | 16 | Request write data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Data captured when the strobe ended |
| ctrlWe | input | 1 | Control register write enable |
| ctrlWdata | input | 11 | Control register write value |
| ctrlQ | output | 11 | Control register contents |
| busAddr | output | 24 | Bus address, valid while busy |
| busDataOut | output | 16 | Bus write data |
| busDataOe | output | 1 | Bus data output enable |
| busDataIn | input | 16 | Bus read data |
| endxN | input | 1 | Active-low early strobe end |
| iorN | output | 1 | I/O read strobe, active low |
| iowN | output | 1 | I/O write strobe, active low |
| memrN | output | 1 | Memory read strobe, active low |
| memwN | output | 1 | Memory write strobe, active low |

## Verification
The embedded properties watch, on every cycle, that at most one strobe is low, that the address does not move while the cycle runs, that a strobe never outlasts its programmed length, that a strobe always falls into the hold phase, that an enabled early end takes effect at once, and that `done` is a single pulse following `busy`. The exact phase lengths, the mapping of access kinds to strobes, the cycle in which read data is sampled, and the freezing of the settings at acceptance can only be shown by the bench scenarios. These scenarios use zero, default, mixed and maximum extensions, early end both enabled and disabled, and writes of requests and control values in the middle of a cycle.

// File: rtl/isa_timer_pkg.sv
package isa_timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // request accepted this edge
    logic capture;   // strobe ends this edge, sample read data
    logic strobeOn;  // strobe phase active
    logic driving;   // any non-idle phase
    logic done;      // completion pulse
  } ctlStrobes_t;

endpackage

// File: rtl/isa_timer_ctrl.sv
module isa_timer_ctrl
  import isa_timer_pkg::*;
#(
  parameter int SETUP_W    = 4,
  parameter int STRB_W     = 6,
  parameter int MIN_TICKS  = 2,
  parameter int HOLD_TICKS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [SETUP_W-1:0] liveSetup,
  input  logic [STRB_W-1:0]  snapStrobe,
  input  logic               snapEarly,
  input  logic               endxN,
  output ctlStrobes_t        ctl,
  output logic               busy
);

  localparam int MAX_SETUP = MIN_TICKS + (1 << SETUP_W) - 1;
  localparam int MAX_STRB  = MIN_TICKS + (1 << STRB_W) - 1;
  localparam int MAX_PH    = (MAX_SETUP > MAX_STRB) ? MAX_SETUP : MAX_STRB;
  localparam int MAX_ALL   = (MAX_PH > HOLD_TICKS) ? MAX_PH : HOLD_TICKS;
  localparam int CNT_W     = $clog2(MAX_ALL + 1);

  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             doneQ;
  logic             lastTick, earlyHit, strobeEnd;

  assign lastTick  = (cnt == '0);
  assign earlyHit  = snapEarly && !endxN;
  assign strobeEnd = (phase == PH_STROBE) && (lastTick || earlyHit);

  always_comb begin
    phaseNext = phase;
    cntNext   = lastTick ? cnt : cnt - 1'b1;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          phaseNext = PH_SETUP;
          cntNext   = CNT_W'(MIN_TICKS - 1) + CNT_W'(liveSetup);
        end
      end
      PH_SETUP: begin
        if (lastTick) begin
          phaseNext = PH_STROBE;
          cntNext   = CNT_W'(MIN_TICKS - 1) + CNT_W'(snapStrobe);
        end
      end
      PH_STROBE: begin
        if (strobeEnd) begin
          phaseNext = PH_HOLD;
          cntNext   = CNT_W'(HOLD_TICKS - 1);
        end
      end
      PH_HOLD: begin
        if (lastTick) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      doneQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      cnt   <= cntNext;
      doneQ <= (phase == PH_HOLD) && lastTick;
    end
  end

  assign busy         = (phase != PH_IDLE);
  assign ctl.load     = (phase == PH_IDLE) && reqValid;
  assign ctl.capture  = strobeEnd;
  assign ctl.strobeOn = (phase == PH_STROBE);
  assign ctl.driving  = busy;
  assign ctl.done     = doneQ;

  // Length of the current strobe run, for the window check below
  logic [CNT_W:0] strobeRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   strobeRun <= '0;
    else if (phase == PH_STROBE) strobeRun <= strobeRun + 1'b1;
    else                         strobeRun <= '0;
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  assert_done_follows_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (!busy && $past(busy)));

  assert_strobe_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE) |-> (strobeRun < (CNT_W+1)'(MIN_TICKS) + (CNT_W+1)'(snapStrobe)));

  assert_strobe_into_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.strobeOn) |-> (phase == PH_HOLD));

  assert_early_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_STROBE) && snapEarly && !endxN) |=> (phase == PH_HOLD));

endmodule

// File: rtl/isa_timer_datapath.sv
module isa_timer_datapath
  import isa_timer_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int SETUP_W   = 4,
  parameter int STRB_W    = 6,
  parameter int SETUP_RST = 14,
  parameter int STRB_RST  = 40
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobes_t               ctl,
  input  logic                      reqWrite,
  input  logic                      reqMem,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic                      ctrlWe,
  input  logic [STRB_W+SETUP_W:0]   ctrlWdata,
  input  logic [DATA_W-1:0]         busDataIn,
  output logic [SETUP_W-1:0]        liveSetup,
  output logic [STRB_W-1:0]         snapStrobe,
  output logic                      snapEarly,
  output logic [STRB_W+SETUP_W:0]   ctrlQ,
  output logic [ADDR_W-1:0]         busAddr,
  output logic [DATA_W-1:0]         busDataOut,
  output logic                      busDataOe,
  output logic                      iorN,
  output logic                      iowN,
  output logic                      memrN,
  output logic                      memwN,
  output logic [DATA_W-1:0]         rdData
);

  localparam int CTRL_W    = STRB_W + SETUP_W + 1;
  localparam int EARLY_BIT = CTRL_W - 1;
  localparam int NUM_KINDS = 4;
  localparam logic [CTRL_W-1:0] CTRL_RST =
    {1'b0, SETUP_W'(SETUP_RST), STRB_W'(STRB_RST)};

  logic [CTRL_W-1:0] ctrlReg;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              writeQ, memQ;
  logic [1:0]        kind;
  logic [NUM_KINDS-1:0] strobeVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ctrlReg <= CTRL_RST;
    else if (ctrlWe) ctrlReg <= ctrlWdata;
  end

  assign ctrlQ     = ctrlReg;
  assign liveSetup = ctrlReg[STRB_W +: SETUP_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ      <= '0;
      dataQ      <= '0;
      writeQ     <= 1'b0;
      memQ       <= 1'b0;
      snapStrobe <= '0;
      snapEarly  <= 1'b0;
    end else if (ctl.load) begin
      addrQ      <= reqAddr;
      dataQ      <= reqWdata;
      writeQ     <= reqWrite;
      memQ       <= reqMem;
      snapStrobe <= ctrlReg[STRB_W-1:0];
      snapEarly  <= ctrlReg[EARLY_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (ctl.capture) rdData <= busDataIn;
  end

  // One strobe line per access kind, indexed by {mem, write}
  assign kind = {memQ, writeQ};
  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_strobe
    assign strobeVec[k] = ctl.strobeOn && (kind == 2'(k));
  end

  assign iorN  = ~strobeVec[0];
  assign iowN  = ~strobeVec[1];
  assign memrN = ~strobeVec[2];
  assign memwN = ~strobeVec[3];

  assign busAddr    = ctl.driving ? addrQ : '0;
  assign busDataOe  = ctl.driving && writeQ;
  assign busDataOut = busDataOe ? dataQ : '0;

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({iorN, iowN, memrN, memwN} ^ 4'hF));

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.driving && $past(ctl.driving)) |-> $stable(busAddr));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(rdData));

  assert_no_strobe_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.driving |-> (iorN && iowN && memrN && memwN));

endmodule

// File: rtl/isa_cycle_timer.sv
module isa_cycle_timer
  import isa_timer_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int SETUP_W    = 4,
  parameter int STRB_W     = 6,
  parameter int MIN_TICKS  = 2,
  parameter int HOLD_TICKS = 2,
  parameter int SETUP_RST  = 14,
  parameter int STRB_RST   = 40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic                    reqMem,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic                    busy,
  output logic                    done,
  output logic [DATA_W-1:0]       rdData,
  input  logic                    ctrlWe,
  input  logic [STRB_W+SETUP_W:0] ctrlWdata,
  output logic [STRB_W+SETUP_W:0] ctrlQ,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [DATA_W-1:0]       busDataOut,
  output logic                    busDataOe,
  input  logic [DATA_W-1:0]       busDataIn,
  input  logic                    endxN,
  output logic                    iorN,
  output logic                    iowN,
  output logic                    memrN,
  output logic                    memwN
);

  ctlStrobes_t        ctl;
  logic [SETUP_W-1:0] liveSetup;
  logic [STRB_W-1:0]  snapStrobe;
  logic               snapEarly;

  isa_timer_ctrl #(
    .SETUP_W(SETUP_W), .STRB_W(STRB_W),
    .MIN_TICKS(MIN_TICKS), .HOLD_TICKS(HOLD_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .liveSetup(liveSetup), .snapStrobe(snapStrobe), .snapEarly(snapEarly),
    .endxN(endxN), .ctl(ctl), .busy(busy)
  );

  isa_timer_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_W(SETUP_W), .STRB_W(STRB_W),
    .SETUP_RST(SETUP_RST), .STRB_RST(STRB_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqWrite(reqWrite), .reqMem(reqMem), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .busDataIn(busDataIn),
    .liveSetup(liveSetup), .snapStrobe(snapStrobe), .snapEarly(snapEarly),
    .ctrlQ(ctrlQ), .busAddr(busAddr), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .iorN(iorN), .iowN(iowN), .memrN(memrN), .memwN(memwN), .rdData(rdData)
  );

  assign done = ctl.done;

endmodule

// File: tb/isa_cycle_timer_bench.sv
module isa_cycle_timer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqMem = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        busy, done;
  logic [15:0] rdData;
  logic        ctrlWe = 1'b0;
  logic [10:0] ctrlWdata = '0;
  logic [10:0] ctrlQ;
  logic [23:0] busAddr;
  logic [15:0] busDataOut;
  logic        busDataOe;
  logic [15:0] busDataIn = '0;
  logic        endxN = 1'b1;
  logic        iorN, iowN, memrN, memwN;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmpOn = 1'b0;

  always #2 clk = ~clk;

  isa_cycle_timer u_isa_cycle_timer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqMem(reqMem),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy), .done(done), .rdData(rdData),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlQ(ctrlQ), .busAddr(busAddr),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .busDataIn(busDataIn), .endxN(endxN),
    .iorN(iorN), .iowN(iowN), .memrN(memrN), .memwN(memwN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Changing read data so the capture edge is visible
  always @(negedge clk) begin
    cyc++;
    busDataIn <= 16'(cyc * 37 + 5);
  end

  // Behavioural reference: phase 0 idle, 1 setup, 2 strobe, 3 hold
  int          mPh = 0, mLeft = 0, mStrb = 0;
  bit          mEn = 0, mW = 0, mM = 0, mDone = 0;
  logic [23:0] mAddr = '0;
  logic [15:0] mWd = '0, mRd = '0;
  logic [10:0] mCtrl = 11'h3A8;

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mLeft = 0; mDone = 0; mRd = '0; mCtrl = 11'h3A8; mAddr = '0;
    end else begin
      bit nd;
      nd = 0;
      case (mPh)
        0: if (reqValid) begin
             mPh = 1; mLeft = 2 + int'(mCtrl[9:6]); mStrb = 2 + int'(mCtrl[5:0]);
             mEn = mCtrl[10]; mW = reqWrite; mM = reqMem; mAddr = reqAddr; mWd = reqWdata;
           end
        1: begin mLeft--; if (mLeft == 0) begin mPh = 2; mLeft = mStrb; end end
        2: begin
             mLeft--;
             if (mLeft == 0 || (mEn && !endxN)) begin mPh = 3; mLeft = 2; mRd = busDataIn; end
           end
        default: begin mLeft--; if (mLeft == 0) begin mPh = 0; nd = 1; end end
      endcase
      mDone = nd;
      if (ctrlWe) mCtrl = ctrlWdata;
    end
  end

  // Compare against the reference on every clock
  always @(negedge clk) begin
    if (cmpOn) begin
      bit s;
      s = (mPh == 2);
      chk("R7 busy", busy, mPh != 0);
      chk("R7 done", done, mDone);
      chk("R4 iorN", iorN, !(s && !mM && !mW));
      chk("R4 iowN", iowN, !(s && !mM && mW));
      chk("R4 memrN", memrN, !(s && mM && !mW));
      chk("R4 memwN", memwN, !(s && mM && mW));
      chk("R11 busDataOe", busDataOe, (mPh != 0) && mW);
      chk("R8 rdData", rdData, mRd);
      chk("R10 ctrlQ", ctrlQ, mCtrl);
      if (mPh != 0) chk("R3 busAddr", busAddr, mAddr);
      if ((mPh != 0) && mW) chk("R11 busDataOut", busDataOut, mWd);
    end
  end

  task automatic setCtrl(input int su, input int st, input bit en);
    @(negedge clk);
    ctrlWe = 1'b1; ctrlWdata = {en, 4'(su), 6'(st)};
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  // Run one cycle; endxAt > 0 drives endxN low after that many strobe cycles
  task automatic runCycle(input bit w, input bit m, input logic [23:0] a, input logic [15:0] d,
                          input int endxAt, input bit midReq, input bit midCtrl,
                          output int busyN, output int strbN);
    busyN = 0; strbN = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqMem = m; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    while (busy) begin
      busyN++;
      if (!(iorN && iowN && memrN && memwN)) begin
        strbN++;
        if (endxAt > 0 && strbN == endxAt) endxN = 1'b0;
      end
      if (midReq && busyN == 2) begin
        reqValid = 1'b1; reqWrite = !w; reqMem = !m; reqAddr = ~a; reqWdata = ~d;
      end else begin
        reqValid = 1'b0;
      end
      ctrlWe = midCtrl && (busyN == 2);
      if (midCtrl) ctrlWdata = 11'h00F;
      if (busyN > 500) break;
      @(negedge clk);
    end
    endxN = 1'b1; ctrlWe = 1'b0; reqValid = 1'b0;
    chk("R7 done after busy", done, 1'b1);
  endtask

  int b, s;

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 strobes", {iorN, iowN, memrN, memwN}, 4'hF);
    chk("R1 busDataOe", busDataOe, 1'b0);
    chk("R1 ctrlQ", ctrlQ, 11'h3A8);
    rstN = 1'b1;
    cmpOn = 1'b1;

    // Defaults: setup 16, strobe 42, hold 2 (R3 R5 R6)
    runCycle(0, 0, 24'h000300, 16'h0, 0, 0, 0, b, s);
    chk("R5 default strobe", s, 42);
    chk("R6 default busy", b, 60);

    // Zero extensions, memory write (R10 R11)
    setCtrl(0, 0, 0);
    chk("R10 ctrlQ zero", ctrlQ, 11'h000);
    runCycle(1, 1, 24'h123456, 16'hBEEF, 0, 0, 0, b, s);
    chk("R5 min strobe", s, 2);
    chk("R3 min busy", b, 6);

    // Mixed values, each access kind (R4)
    setCtrl(3, 5, 0);
    runCycle(1, 0, 24'h0000A0, 16'h1234, 0, 0, 0, b, s);
    chk("R3 mixed busy", b, 14);
    chk("R5 mixed strobe", s, 7);
    runCycle(0, 1, 24'h0A0000, 16'h0, 0, 0, 0, b, s);
    chk("R4 mem read busy", b, 14);

    // Early end enabled (R9)
    setCtrl(3, 10, 1);
    runCycle(0, 0, 24'h000055, 16'h0, 1, 0, 0, b, s);
    chk("R9 early strobe 1", s, 1);
    chk("R9 early busy", b, 8);
    runCycle(0, 1, 24'h000066, 16'h0, 4, 0, 0, b, s);
    chk("R9 early strobe 4", s, 4);

    // Early end disabled: endxN ignored (R9)
    setCtrl(3, 10, 0);
    runCycle(0, 0, 24'h000077, 16'h0, 1, 0, 0, b, s);
    chk("R9 ignored strobe", s, 12);

    // Request while busy ignored (R2)
    setCtrl(2, 3, 0);
    runCycle(1, 0, 24'h00CAFE, 16'h5A5A, 0, 1, 0, b, s);
    chk("R2 busy len", b, 11);
    chk("R2 strobe len", s, 5);
    @(negedge clk);
    chk("R2 still idle", busy, 1'b0);

    // Control write during a cycle does not change it (R10)
    runCycle(0, 1, 24'h00BEEF, 16'h0, 0, 0, 1, b, s);
    chk("R10 frozen strobe", s, 5);
    chk("R10 new value", ctrlQ, 11'h00F);

    // Maximum extensions
    setCtrl(15, 63, 0);
    runCycle(1, 1, 24'hFFFFFF, 16'hFFFF, 0, 0, 0, b, s);
    chk("R5 max strobe", s, 65);
    chk("R3 max busy", b, 84);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule